// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers bus requests to downstream targets through eight software-programmed address windows. Each window holds a control word, a base address and, for the lower-numbered windows, a pair of remap words. A window's size is given as a mask of 64 KB units. Ones in the mask mark address bits that fall inside the window. All zeros still gives a 64 KB window.

Each request address is compared against every enabled window in parallel. The lowest-numbered matching window selects the target identifier and attribute. It also sets the translated address. When no enabled window matches, the response carries a miss. Software writes and reads the window registers through a flat configuration port. Read data is returned combinationally from the selected register.

Responses are registered and appear one clock after the request. A configuration write and a request may fall in the same cycle. In that case the request is judged against the configuration that held before the write.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous active-low reset every window register reads as zero, every window is disabled and `rsp_valid`, `rsp_hit` and `rsp_miss` are low.
- R2: Register addressing is `cfg_addr[4:2]` = window number and `cfg_addr[1:0]` = register select (0 control, 1 base, 2 low remap, 3 high remap). A write with `cfg_wr` high stores all 32 bits, and a later read at the same address returns them.
- R3: Windows 4 to 7 have no remap registers. Their select values 2 and 3 always read zero, and writes to them are discarded.
- R4: The control word holds the enable in bit 0, the target identifier in bits 7:4, the attribute in bits 15:8 and the size mask in bits 31:16. A window whose enable bit is clear never produces a hit.
- R5: An address hits an enabled window when `(addr[31:16] & ~size) == (base[31:16] & ~size)`. A size of zero therefore gives a 64 KB window.
- R6: A size of 0x00FF gives a 16 MB window. The last byte of the window hits, and the first byte past it does not hit that window.
- R7: When several enabled windows match, the lowest-numbered one supplies the target, the attribute, the window number and the translation.
- R8: For windows 0 to 3 the translated address is `{(remap_lo[31:16] & ~size) | (addr[31:16] & size), addr[15:0]}`.
- R9: A hit in windows 4 to 7 returns the request address unchanged.
- R10: On a miss, `rsp_miss` is high and `rsp_hit` is low. The target and attribute are zero, and `rsp_addr` equals the request address.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_hit` and `rsp_miss` are low whenever `rsp_valid` is low.
- R12: A size mask that is not a contiguous run of ones is used exactly as written.
- R13: A request presented in the same cycle as a configuration write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Window number and register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | 3 | Number of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
A configuration write and a request decode can fall in the same clock. The bench provokes this by raising `cfg_wr` to enable a disabled window while `req_valid` carries an address inside that window. The response must report a miss. A second request in a later cycle must then hit the newly enabled window with its target, attribute and translation. Overlapping windows and windows with and without remap are covered by a table of requests with expected responses.

// File: rtl/addr_win_pkg.sv
// Package: shared field layout and register-select encoding for the
// address window decoder. Assumes a 32-bit address and 64 KB granules.
package addr_win_pkg;

    localparam int ADDR_W   = 32;
    localparam int GRAN_W   = 16;               // offset bits inside one 64 KB granule
    localparam int MASK_W   = ADDR_W - GRAN_W;  // width of the size mask
    localparam int TGT_W    = 4;
    localparam int ATTR_W   = 8;
    localparam int SEL_W    = 2;

    // Control word layout; bit 0 is the enable
    typedef struct packed {
        logic [MASK_W-1:0] size;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  target;
        logic [2:0]        spare;
        logic              en;
    } win_ctrl_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL     = 2'd0,
        SEL_BASE     = 2'd1,
        SEL_REMAP_LO = 2'd2,
        SEL_REMAP_HI = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/addr_win_regs.sv
// Module: window register file. Holds control and base for every window,
// and remap low/high only for windows below NUM_REMAP. Unimplemented
// registers read zero and ignore writes. Read is combinational.
module addr_win_regs
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int CFG_AW   = IDX_W + SEL_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [CFG_AW-1:0]                addr,
    input  logic [ADDR_W-1:0]                wdata,
    output logic [ADDR_W-1:0]                rdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   ctrl_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_lo_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_hi_q
);

    logic [IDX_W-1:0] win_sel;
    reg_sel_e         reg_sel;

    assign win_sel = addr[CFG_AW-1:SEL_W];
    assign reg_sel = reg_sel_e'(addr[SEL_W-1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit_w;
        assign hit_w = wr_en && (win_sel == IDX_W'(w));

        // Purpose: hold control and base words of this window
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[w] <= '0;
                base_q[w] <= '0;
            end else if (hit_w) begin
                if (reg_sel == SEL_CTRL) ctrl_q[w] <= wdata;
                if (reg_sel == SEL_BASE) base_q[w] <= wdata;
            end
        end

        if (w < NUM_REMAP) begin : g_remap
            // Purpose: hold remap words of a window that translates
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    remap_lo_q[w] <= '0;
                    remap_hi_q[w] <= '0;
                end else if (hit_w) begin
                    if (reg_sel == SEL_REMAP_LO) remap_lo_q[w] <= wdata;
                    if (reg_sel == SEL_REMAP_HI) remap_hi_q[w] <= wdata;
                end
            end
        end else begin : g_no_remap
            assign remap_lo_q[w] = '0;
            assign remap_hi_q[w] = '0;
        end
    end

    // Purpose: return the addressed register for software reads
    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:     rdata = ctrl_q[win_sel];
            SEL_BASE:     rdata = base_q[win_sel];
            SEL_REMAP_LO: rdata = remap_lo_q[win_sel];
            SEL_REMAP_HI: rdata = remap_hi_q[win_sel];
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/addr_win_match.sv
// Module: one window comparator and translator. Hit when the window is
// enabled and the address agrees with the base on every bit the size
// mask leaves clear. HAS_REMAP selects translation or pass-through.
module addr_win_match
    import addr_win_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b1
) (
    input  logic [ADDR_W-1:0] ctrl,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] remap_lo,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat
);

    win_ctrl_t         cw;
    logic [MASK_W-1:0] keep;   // bits that must equal the base

    assign cw   = win_ctrl_t'(ctrl);
    assign keep = ~cw.size;

    // Purpose: compare the masked upper address against the masked base
    always_comb begin
        hit = cw.en && ((addr[ADDR_W-1:GRAN_W] & keep) == (base[ADDR_W-1:GRAN_W] & keep));
    end

    if (HAS_REMAP) begin : g_xlat
        // Purpose: splice remap upper bits with the in-window offset
        always_comb begin
            xlat = {(remap_lo[ADDR_W-1:GRAN_W] & keep) | (addr[ADDR_W-1:GRAN_W] & cw.size),
                    addr[GRAN_W-1:0]};
        end
    end else begin : g_pass
        assign xlat = addr;
    end

endmodule

// File: rtl/addr_win_prio.sv
// Module: fixed-priority resolver. Picks the lowest-numbered asserted
// hit and reports whether any hit is present.
module addr_win_prio #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Purpose: scan from the top so the lowest hit is assigned last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/addr_window_decoder.sv
// Module: top of the address window decoder. Holds the registers, runs
// every window comparator in parallel, resolves priority and registers
// the response one cycle after the request. Assumes synchronous
// active-low reset and that cfg_rdata is sampled combinationally.
module addr_window_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int CFG_AW   = IDX_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [TGT_W-1:0]  rsp_target,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic [ADDR_W-1:0] rsp_addr
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] remap_lo_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] remap_hi_q;
    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_xlat;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel_idx;
    win_ctrl_t                      sel_ctrl;

    addr_win_regs #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .ctrl_q     (ctrl_q),
        .base_q     (base_q),
        .remap_lo_q (remap_lo_q),
        .remap_hi_q (remap_hi_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        addr_win_match #(
            .HAS_REMAP (w < NUM_REMAP)
        ) u_match (
            .ctrl     (ctrl_q[w]),
            .base     (base_q[w]),
            .remap_lo (remap_lo_q[w]),
            .addr     (req_addr),
            .hit      (win_hit[w]),
            .xlat     (win_xlat[w])
        );
    end

    addr_win_prio #(
        .NUM_WIN (NUM_WIN)
    ) u_prio (
        .hits (win_hit),
        .any  (any_hit),
        .idx  (sel_idx)
    );

    assign sel_ctrl = win_ctrl_t'(ctrl_q[sel_idx]);

    // Purpose: register the decode result one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_win    <= '0;
            rsp_target <= '0;
            rsp_attr   <= '0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && any_hit;
            rsp_miss  <= req_valid && !any_hit;
            if (req_valid && any_hit) begin
                rsp_win    <= sel_idx;
                rsp_target <= sel_ctrl.target;
                rsp_attr   <= sel_ctrl.attr;
                rsp_addr   <= win_xlat[sel_idx];
            end else if (req_valid) begin
                rsp_win    <= '0;
                rsp_target <= '0;
                rsp_attr   <= '0;
                rsp_addr   <= req_addr;
            end
        end
    end

endmodule

// File: rtl/addr_window_decoder_chk.sv
// Module: property checker for the address window decoder, bound to the
// top. Observes ports only.
module addr_window_decoder_chk
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int CFG_AW   = IDX_W + SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [IDX_W-1:0]  rsp_win,
    input logic [TGT_W-1:0]  rsp_target,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic [ADDR_W-1:0] rsp_addr
);

    logic rd_no_remap;
    assign rd_no_remap = (32'(cfg_addr[CFG_AW-1:SEL_W]) >= NUM_REMAP) && cfg_addr[1];

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11
    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11
    AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R11
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss)); // R10
    AST_MISS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_target == '0 && rsp_attr == '0)); // R10
    AST_MISS_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_miss || rsp_addr == $past(req_addr))); // R10
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr[GRAN_W-1:0] == $past(req_addr[GRAN_W-1:0]))); // R8
    AST_UPPER_WIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!(rsp_hit && 32'(rsp_win) >= NUM_REMAP) || rsp_addr == $past(req_addr))); // R9
    AST_NO_REMAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_no_remap |-> (cfg_rdata == '0)); // R3

endmodule

bind addr_window_decoder addr_window_decoder_chk #(
    .NUM_WIN   (NUM_WIN),
    .NUM_REMAP (NUM_REMAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_win    (rsp_win),
    .rsp_target (rsp_target),
    .rsp_attr   (rsp_attr),
    .rsp_addr   (rsp_addr)
);

// File: tb/addr_window_decoder_bench.sv
`timescale 1ns/1ps
module addr_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] rsp_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_target(rsp_target),
        .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] xaddr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h9123_4567, 1'b1, 3'd0, 4'h4, 8'hE8, 32'h4123_4567},
        '{32'hC000_1234, 1'b1, 3'd1, 4'h4, 8'hE0, 32'h0000_1234},
        '{32'hC001_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'hC001_0000},
        '{32'hD8AB_CDEF, 1'b1, 3'd2, 4'h1, 8'h2F, 32'h20AB_CDEF},
        '{32'hD8FF_FFFF, 1'b1, 3'd2, 4'h1, 8'h2F, 32'h20FF_FFFF},
        '{32'hD900_0000, 1'b1, 3'd6, 4'hA, 8'h55, 32'hD900_0000},
        '{32'h5000_0010, 1'b0, 3'd0, 4'h0, 8'h00, 32'h5000_0010},
        '{32'hF812_3456, 1'b1, 3'd4, 4'h1, 8'h0F, 32'hF812_3456},
        '{32'hC800_FFFF, 1'b1, 3'd5, 4'h3, 8'h01, 32'hC800_FFFF},
        '{32'hC801_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'hC801_0000},
        '{32'h6101_0005, 1'b1, 3'd7, 4'hB, 8'h77, 32'h6101_0005},
        '{32'h6002_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h6002_0000},
        '{32'h0000_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0000_0000}
    };
    string vtag [NV];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {w, s}; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = {w, s};
        #1 d = cfg_rdata;
    endtask

    task automatic req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        vtag = '{"R8", "R5", "R5", "R7", "R6", "R6", "R4", "R9", "R9", "R5", "R12", "R12", "R10"};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 rsp_hit/miss", {30'd0, rsp_hit, rsp_miss}, 32'd0);
        rd(3'd0, 2'd0, d); check("R1 ctrl0", d, 32'd0);
        rd(3'd7, 2'd1, d); check("R1 base7", d, 32'd0);
        rd(3'd2, 2'd2, d); check("R1 remap_lo2", d, 32'd0);
        req(32'h0000_0000);
        check("R1 miss when all disabled", {31'd0, rsp_miss}, 32'd1);

        // configure windows
        wr(3'd0, 2'd0, 32'h0FFF_E841); wr(3'd0, 2'd1, 32'h9000_0000); wr(3'd0, 2'd2, 32'h4000_0000);
        wr(3'd1, 2'd0, 32'h0000_E041); wr(3'd1, 2'd1, 32'hC000_0000); wr(3'd1, 2'd2, 32'h0000_0000);
        wr(3'd2, 2'd0, 32'h00FF_2F11); wr(3'd2, 2'd1, 32'hD800_0000); wr(3'd2, 2'd2, 32'h2000_0000);
        wr(3'd3, 2'd0, 32'h00FF_1E10); wr(3'd3, 2'd1, 32'h5000_0000); wr(3'd3, 2'd2, 32'h5000_0000);
        wr(3'd4, 2'd0, 32'h07FF_0F11); wr(3'd4, 2'd1, 32'hF800_0000); wr(3'd4, 2'd2, 32'h1234_0000);
        wr(3'd4, 2'd3, 32'hFFFF_FFFF);
        wr(3'd5, 2'd0, 32'h0000_0131); wr(3'd5, 2'd1, 32'hC800_0000);
        wr(3'd6, 2'd0, 32'h0FFF_55A1); wr(3'd6, 2'd1, 32'hD000_0000);
        wr(3'd7, 2'd0, 32'h0101_77B1); wr(3'd7, 2'd1, 32'h6000_0000);
        wr(3'd0, 2'd3, 32'h0000_ABCD);

        // R2: readback
        rd(3'd2, 2'd0, d); check("R2 ctrl2", d, 32'h00FF_2F11);
        rd(3'd6, 2'd1, d); check("R2 base6", d, 32'hD000_0000);
        rd(3'd0, 2'd3, d); check("R2 remap_hi0", d, 32'h0000_ABCD);
        // R3: missing remap registers
        rd(3'd4, 2'd2, d); check("R3 remap_lo4", d, 32'd0);
        rd(3'd4, 2'd3, d); check("R3 remap_hi4", d, 32'd0);

        // table of requests
        for (int i = 0; i < NV; i++) begin
            req(VECS[i].addr);
            check({vtag[i], " valid"}, {31'd0, rsp_valid}, 32'd1);
            check({vtag[i], " hit/miss"}, {30'd0, rsp_hit, rsp_miss}, {30'd0, VECS[i].hit, !VECS[i].hit});
            check({vtag[i], " tgt/attr"}, {20'd0, rsp_target, rsp_attr}, {20'd0, VECS[i].tgt, VECS[i].attr});
            check({vtag[i], " addr"}, rsp_addr, VECS[i].xaddr);
            if (VECS[i].hit) check({vtag[i], " win"}, {29'd0, rsp_win}, {29'd0, VECS[i].win});
        end

        // R11: idle cycle gives no response
        @(negedge clk);
        check("R11 idle", {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'd0);

        // R13: enable window 3 in the same cycle as a request into it
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {3'd3, 2'd0}; cfg_wdata = 32'h00FF_1E11;
        req_valid = 1'b1; req_addr = 32'h5000_0010;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        check("R13 old config miss", {30'd0, rsp_hit, rsp_miss}, 32'd1);
        req(32'h5000_0010);
        check("R13 new config hit", {30'd0, rsp_hit, rsp_miss}, 32'd2);
        check("R13 win", {29'd0, rsp_win}, 32'd3);
        check("R13 tgt/attr", {20'd0, rsp_target, rsp_attr}, 32'h0000_011E);
        check("R13 addr", rsp_addr, 32'h5000_0010);

        // R4: disable window 2; the same address now falls to window 6
        wr(3'd2, 2'd0, 32'h00FF_2F10);
        req(32'hD8AB_CDEF);
        check("R4 disabled window skipped", {29'd0, rsp_win}, 32'd6);
        check("R4 addr pass", rsp_addr, 32'hD8AB_CDEF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule